// File: doc/BRIEF.md
# Die Temperature Report Formatter

This block sits between an on-die thermal sensor and the management port that answers temperature queries from a host. Each accepted sample is a 16-bit two's complement value in 1/64 °C units. It gives the distance below the maximum junction temperature, so a healthy reading is zero or negative. The block keeps two read words, each 32 bits wide with the upper half held at zero:

- **Instantaneous word:** the most recent accepted reading.
- **Filtered word:** an exponential running average. The host sets how fast it responds by writing a shift constant.

When the sensor reports a fault or an out-of-range condition, both words carry a reserved code instead of a temperature. A fault or range condition never disturbs the stored average. Sanitising logic moves any real reading that would collide with a reserved code out of the code space, and caps positive readings at zero.

A small controller tracks what the words currently show. The states are:

- **ST_EMPTY:** after reset, no reading yet.
- **ST_TRACK:** showing a valid reading.
- **ST_FAULT:** sensor fault.
- **ST_LOW:** below range.
- **ST_HIGH:** above range.

A state changes only when `smp_valid` is high. The transitions are:

- **Fault:** `flt_sensor` high moves the controller to ST_FAULT.
- **High:** `flt_high` high, with no fault, moves it to ST_HIGH.
- **Low:** `flt_low` high, with neither of the others, moves it to ST_LOW.
- **Good:** no flag high moves it to ST_TRACK.

Any state can take any of these transitions. With `smp_valid` low, every state holds.

Top module: `temp_report_fmt`

## Requirements
- R1: After reset, and until the first sample is accepted, both words read 0x0000_8000.
- R2: A valid sample with `flt_sensor` high makes both words 0x0000_8000 from the next cycle. The running average and its seeded status stay unchanged.
- R3: A valid sample with `flt_high` high and no fault makes both words 0x0000_8003. With only `flt_low` high, both words read 0x0000_8002. The priority is fault, then high, then low. Neither code touches the average.
- R4: A valid sample with no flag is shown on the instantaneous word in the next cycle, after sanitising. A positive value reads as 0x0000. A value from 0x8000 to 0x8003 reads as 0x8004. Any other value passes unchanged.
- R5: Bits 31:16 of both words are always zero. Bits 15:0 hold the 16-bit temperature or code.
- R6: The first good sample after reset seeds the average with the sanitised sample. This holds even when fault or range samples came first.
- R7: Each later good sample sanitises the input to s and updates the average as avg + ((s − avg) >>> k). The subtraction is 17-bit signed and the shift is arithmetic, so it rounds toward minus infinity. With k = 0 the filtered word equals the sample. In ST_TRACK the filtered word shows the average.
- R8: A write on `kcfg_we` loads the 4-bit constant k; reset loads the parameter `K_INIT` (default 2). A sample accepted in the same cycle as a write still uses the old k.
- R9: With `smp_valid` low, both words hold, whatever the flags and the constant port do.
- R10: After a fault or range state, the next good sample returns the controller to ST_TRACK. The average continues from the value it held before that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe; flags and value are taken only with it |
| smp_temp | input | 16 | Relative temperature, 1/64 °C, two's complement |
| flt_sensor | input | 1 | Sensor fault flag |
| flt_low | input | 1 | Reading below sensor range |
| flt_high | input | 1 | Reading above sensor range |
| kcfg_we | input | 1 | Averaging constant write strobe |
| kcfg_val | input | 4 | Averaging shift constant k |
| inst_word | output | 32 | Instantaneous temperature response |
| filt_word | output | 32 | Filtered temperature response |

## Verification
A constant write and a sample can fall in the same cycle. The bench drives `kcfg_we` together with `smp_valid` and expects the sample's average to be computed with the old k, and the following sample with the new k. A sample can also carry several flags at once. Combined fault, high and low flags are driven in one strobe, and the winning code is judged against the priority of R3. A good sample that follows then shows that the frozen average was not touched.

// File: rtl/trf_pkg.sv
package trf_pkg;
    localparam int TEMP_W = 16;
    localparam int RESP_W = 32;
    localparam int KSH_W  = 4;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_TRACK,
        ST_FAULT,
        ST_LOW,
        ST_HIGH
    } trf_state_e;
endpackage

// File: rtl/trf_sanitize.sv
// Moves real readings out of the reserved code block and caps positives at zero.
module trf_sanitize #(
    parameter int TW = trf_pkg::TEMP_W
) (
    input  logic [TW-1:0] raw,
    output logic [TW-1:0] clean
);
    localparam logic [TW-1:0] MIN_NEG  = {1'b1, {(TW-1){1'b0}}};
    localparam logic [TW-1:0] FIRST_OK = MIN_NEG + TW'(4);

    logic is_positive;
    logic in_codes;

    always_comb begin
        is_positive = !raw[TW-1] && (raw != '0);
        in_codes    = (raw[TW-1:2] == MIN_NEG[TW-1:2]);
        if (is_positive) begin
            clean = '0;
        end else if (in_codes) begin
            clean = FIRST_OK;
        end else begin
            clean = raw;
        end
    end
endmodule

// File: rtl/trf_ewma.sv
// Exponential average register with seed-on-first-sample.
module trf_ewma #(
    parameter int TW = trf_pkg::TEMP_W,
    parameter int KW = trf_pkg::KSH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [KW-1:0] shift_k,
    input  logic [TW-1:0] sample,
    output logic [TW-1:0] avg,
    output logic          seeded
);
    logic signed [TW:0] diff;
    logic signed [TW:0] step;
    logic [TW-1:0]      avg_next;

    always_comb begin
        diff     = $signed({sample[TW-1], sample}) - $signed({avg[TW-1], avg});
        step     = diff >>> shift_k;
        avg_next = avg + step[TW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg    <= '0;
            seeded <= 1'b0;
        end else if (load) begin
            avg    <= seeded ? avg_next : sample;
            seeded <= 1'b1;
        end
    end
endmodule

// File: rtl/trf_ctrl.sv
// Report state controller: which kind of content the read words show.
module trf_ctrl
    import trf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic       flt_sensor,
    input  logic       flt_low,
    input  logic       flt_high,
    output trf_state_e state,
    output logic       accept_good
);
    trf_state_e nxt;
    trf_state_e verdict;

    always_comb begin
        if (flt_sensor) begin
            verdict = ST_FAULT;
        end else if (flt_high) begin
            verdict = ST_HIGH;
        end else if (flt_low) begin
            verdict = ST_LOW;
        end else begin
            verdict = ST_TRACK;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_EMPTY: if (smp_valid) nxt = verdict;
            ST_TRACK: if (smp_valid) nxt = verdict;
            ST_FAULT: if (smp_valid) nxt = verdict;
            ST_LOW:   if (smp_valid) nxt = verdict;
            ST_HIGH:  if (smp_valid) nxt = verdict;
            default:  nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        accept_good = smp_valid && (verdict == ST_TRACK);
    end
endmodule

// File: rtl/temp_report_fmt.sv
module temp_report_fmt
    import trf_pkg::*;
#(
    parameter int          TW     = TEMP_W,
    parameter int          RW     = RESP_W,
    parameter int          KW     = KSH_W,
    parameter logic [3:0]  K_INIT = 4'd2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [TW-1:0] smp_temp,
    input  logic          flt_sensor,
    input  logic          flt_low,
    input  logic          flt_high,
    input  logic          kcfg_we,
    input  logic [KW-1:0] kcfg_val,
    output logic [RW-1:0] inst_word,
    output logic [RW-1:0] filt_word
);
    localparam int            PAD_W     = RW - TW;
    localparam logic [TW-1:0] CODE_GSE  = {1'b1, {(TW-1){1'b0}}};
    localparam logic [TW-1:0] CODE_LOW  = CODE_GSE + TW'(2);
    localparam logic [TW-1:0] CODE_HIGH = CODE_GSE + TW'(3);

    trf_state_e    state;
    logic          accept_good;
    logic [TW-1:0] clean;
    logic [TW-1:0] avg;
    logic          seeded;
    logic [KW-1:0] k_q;
    logic [TW-1:0] inst_q;
    logic [TW-1:0] inst_lo;
    logic [TW-1:0] filt_lo;

    trf_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .flt_sensor  (flt_sensor),
        .flt_low     (flt_low),
        .flt_high    (flt_high),
        .state       (state),
        .accept_good (accept_good)
    );

    trf_sanitize #(.TW(TW)) u_san (
        .raw   (smp_temp),
        .clean (clean)
    );

    trf_ewma #(.TW(TW), .KW(KW)) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept_good),
        .shift_k (k_q),
        .sample  (clean),
        .avg     (avg),
        .seeded  (seeded)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= KW'(K_INIT);
        end else if (kcfg_we) begin
            k_q <= kcfg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inst_q <= '0;
        end else if (accept_good) begin
            inst_q <= clean;
        end
    end

    always_comb begin
        unique case (state)
            ST_TRACK: begin
                inst_lo = inst_q;
                filt_lo = avg;
            end
            ST_LOW: begin
                inst_lo = CODE_LOW;
                filt_lo = CODE_LOW;
            end
            ST_HIGH: begin
                inst_lo = CODE_HIGH;
                filt_lo = CODE_HIGH;
            end
            ST_EMPTY, ST_FAULT: begin
                inst_lo = CODE_GSE;
                filt_lo = CODE_GSE;
            end
            default: begin
                inst_lo = CODE_GSE;
                filt_lo = CODE_GSE;
            end
        endcase
        inst_word = {{PAD_W{1'b0}}, inst_lo};
        filt_word = {{PAD_W{1'b0}}, filt_lo};
    end
endmodule

// File: rtl/trf_checker.sv
module trf_checker #(
    parameter int TW = 16,
    parameter int RW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          flt_sensor,
    input logic          flt_low,
    input logic          flt_high,
    input logic [RW-1:0] inst_word,
    input logic [RW-1:0] filt_word
);
    localparam logic [TW-1:0] GSE = {1'b1, {(TW-1){1'b0}}};

    a_r2_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && flt_sensor |=> inst_word[TW-1:0] == GSE && filt_word[TW-1:0] == GSE);

    a_r3_high_code: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !flt_sensor && flt_high |=>
            inst_word[TW-1:0] == GSE + TW'(3) && filt_word[TW-1:0] == GSE + TW'(3));

    a_r3_low_code: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !flt_sensor && !flt_high && flt_low |=>
            inst_word[TW-1:0] == GSE + TW'(2) && filt_word[TW-1:0] == GSE + TW'(2));

    a_r4_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !flt_sensor && !flt_high && !flt_low |=>
            inst_word[TW-1:2] != GSE[TW-1:2] && filt_word[TW-1:2] != GSE[TW-1:2]
            && (inst_word[TW-1] || inst_word[TW-1:0] == '0));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(inst_word) && $stable(filt_word));

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> inst_word[RW-1:TW] == '0 && filt_word[RW-1:TW] == '0);
endmodule

bind temp_report_fmt trf_checker #(.TW(TW), .RW(RW)) u_trf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .flt_sensor (flt_sensor),
    .flt_low    (flt_low),
    .flt_high   (flt_high),
    .inst_word  (inst_word),
    .filt_word  (filt_word)
);

// File: tb/temp_report_fmt_tb.sv
module temp_report_fmt_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_temp = '0;
    logic        flt_sensor = 1'b0;
    logic        flt_low = 1'b0;
    logic        flt_high = 1'b0;
    logic        kcfg_we = 1'b0;
    logic [3:0]  kcfg_val = '0;
    logic [31:0] inst_word;
    logic [31:0] filt_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] q_inst[$];
    logic [31:0] q_filt[$];
    string       q_tag[$];

    // reference model state
    int          m_k;
    logic [15:0] m_avg;
    bit          m_seeded;
    logic [31:0] m_inst;
    logic [31:0] m_filt;

    always #(CLK_PERIOD/2) clk = ~clk;

    temp_report_fmt u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_temp   (smp_temp),
        .flt_sensor (flt_sensor),
        .flt_low    (flt_low),
        .flt_high   (flt_high),
        .kcfg_we    (kcfg_we),
        .kcfg_val   (kcfg_val),
        .inst_word  (inst_word),
        .filt_word  (filt_word)
    );

    function automatic logic [15:0] sanitize(input logic [15:0] s);
        if ($signed(s) > 0) return 16'h0000;
        if (s >= 16'h8000 && s <= 16'h8003) return 16'h8004;
        return s;
    endfunction

    task automatic model_reset();
        m_k = 2; m_avg = '0; m_seeded = 0;
        m_inst = 32'h0000_8000; m_filt = 32'h0000_8000;
    endtask

    task automatic push_exp(input string tag);
        q_inst.push_back(m_inst);
        q_filt.push_back(m_filt);
        q_tag.push_back(tag);
    endtask

    task automatic drive(input bit v, input logic [15:0] s, input bit f, input bit hi,
                         input bit lo, input bit we, input logic [3:0] kw, input string tag);
        logic [15:0] c;
        int d;
        @(negedge clk);
        smp_valid = v; smp_temp = s; flt_sensor = f; flt_high = hi; flt_low = lo;
        kcfg_we = we; kcfg_val = kw;
        if (v) begin
            if (f) begin
                m_inst = 32'h8000; m_filt = 32'h8000;
            end else if (hi) begin
                m_inst = 32'h8003; m_filt = 32'h8003;
            end else if (lo) begin
                m_inst = 32'h8002; m_filt = 32'h8002;
            end else begin
                c = sanitize(s);
                if (!m_seeded) begin
                    m_avg = c; m_seeded = 1;
                end else begin
                    d = int'($signed(c)) - int'($signed(m_avg));
                    d = d >>> m_k;
                    m_avg = 16'(int'($signed(m_avg)) + d);
                end
                m_inst = {16'h0, c}; m_filt = {16'h0, m_avg};
            end
        end
        if (we) m_k = int'(kw);
        @(posedge clk);
        push_exp(tag);
        #1;
        smp_valid = 0; kcfg_we = 0; flt_sensor = 0; flt_high = 0; flt_low = 0;
    endtask

    task automatic good(input logic [15:0] s, input string tag);
        drive(1, s, 0, 0, 0, 0, 4'd0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // monitor: compares the oldest expectation on the falling edge after it was pushed
    always @(negedge clk) begin
        if (q_inst.size() > 0) begin
            logic [31:0] ei, ef;
            string t;
            ei = q_inst.pop_front(); ef = q_filt.pop_front(); t = q_tag.pop_front();
            n_cmp++;
            if (inst_word !== ei || filt_word !== ef) begin
                n_bad++;
                $display("FAIL %s: inst=%h filt=%h expected inst=%h filt=%h",
                         t, inst_word, filt_word, ei, ef);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (2) @(negedge clk);
        // R1: reset value visible while still in reset
        n_cmp++;
        if (inst_word !== 32'h8000 || filt_word !== 32'h8000) begin
            n_bad++;
            $display("FAIL R1: inst=%h filt=%h expected 00008000", inst_word, filt_word);
        end
        rst_n = 1;
        drive(0, 16'hFD80, 1, 1, 1, 0, 4'd0, "R1 idle after reset");
        drive(0, 16'h1234, 1, 0, 0, 0, 4'd0, "R9 flags ignored without strobe");
        good(16'hFD80, "R6 seed");
        good(16'hFB00, "R7 k=2 step");
        good(16'h0100, "R4 positive capped");
        good(16'h8001, "R4 code collision");
        good(16'h8000, "R4 0x8000 moved");
        good(16'h8004, "R4 0x8004 passes");
        good(16'hF000, "R7 recover toward sample");
        drive(1, 16'hE000, 1, 0, 0, 0, 4'd0, "R2 fault");
        drive(0, 16'h0000, 0, 0, 0, 0, 4'd0, "R9 hold fault");
        good(16'hF800, "R10 resume after fault");
        drive(1, 16'h0000, 0, 1, 0, 0, 4'd0, "R3 high");
        drive(1, 16'h0000, 0, 1, 1, 0, 4'd0, "R3 high over low");
        drive(1, 16'h0000, 1, 1, 1, 0, 4'd0, "R3 fault over all");
        drive(1, 16'h0000, 0, 0, 1, 0, 4'd0, "R3 low");
        good(16'hFC00, "R10 resume after range");
        drive(1, 16'hF400, 0, 0, 0, 1, 4'd0, "R8 write same cycle uses old k");
        good(16'hFA00, "R7 k=0 follows sample");
        drive(0, 16'h0000, 0, 0, 0, 1, 4'd15, "R8 write without strobe holds words");
        good(16'hC000, "R8 k=15 slow step");
        good(16'hC000, "R8 k=15 second step");
        drive(0, 16'h0000, 0, 0, 0, 1, 4'd1, "R8 set k=1");
        good(16'hD000, "R7 k=1 halving");
        good(16'hFFFF, "R7 k=1 small diff floor");
        do_reset();
        drive(0, 16'h0000, 0, 0, 0, 0, 4'd0, "R1 after second reset");
        drive(1, 16'hF000, 1, 0, 0, 0, 4'd0, "R2 fault before seed");
        drive(1, 16'hF000, 0, 0, 1, 0, 4'd0, "R3 low before seed");
        good(16'hEC00, "R6 seed after fault");
        good(16'hF000, "R7 k reset default");
        drive(0, 16'h0000, 0, 0, 0, 0, 4'd0, "R5 upper half zero hold");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule